// File: doc/BRIEF.md
# Timer Channel Waveform Generator

One 16-bit timer channel that runs in waveform mode and drives two output lines, A and B. A single 32-bit configuration word sets the counting scheme, the source and edge of the external event, and a 2-bit action for each event source on each output. The possible actions are none, set, clear and toggle. A count tick input stands in for the selected counter clock. Enable, disable and software-trigger command pulses control the counter.

The counter can run up-only and wrap, restart automatically when it matches the C compare value, or run as a triangle that turns around at its top and at zero. Compare matches on values A, B and C, the external event and the software trigger each act on the outputs. When more than one of them acts on the same output in the same cycle, a fixed priority picks the winner. A match on C can also stop or disable the counter clock. When the external event is routed from line B and enabled as a trigger, line B becomes an input and its driver turns off.

Top module: `tc_wave_chan`

## Requirements
- R1: After reset the count is 0, both outputs are low, `ovf_o` is low, `run_o` is low and, with `mode_i` = 0, `tiob_oe_o` is low.
- R2: While mode bit 15 (waveform enable) is clear, the count does not change, neither output changes, the software trigger and the external event have no effect, and `tiob_oe_o` is low.
- R3: A tick is a cycle in which `tick_i` is high, the clock is enabled and not stopped, and bit 15 is set. With bits 14 and 13 clear, each tick increments the count by one and 0xFFFF wraps to 0. Outside ticks and triggers the count holds.
- R4: With bit 14 set and bit 13 clear, a tick that finds the count equal to `rc_i` loads 0 at that edge.
- R5: With bit 13 set, the count rises to its top (`rc_i` when bit 14 is set, otherwise 0xFFFF), then falls to 0, then rises again. The turn at either end takes one tick.
- R6: Output A takes its actions from fields [17:16] (A compare), [19:18] (C compare), [21:20] (external event) and [23:22] (software trigger). Output B takes them from [25:24] (B compare), [27:26], [29:28] and [31:30]. In each field, 00 means none, 01 set, 10 clear and 11 toggle. A compare event occurs on a tick whose count equals the compare value. The output register changes at the edge where the event occurs.
- R7: When several events with non-zero actions hit one output in the same cycle, only one of them acts. The order is software trigger first, then external event, then C compare, then the A or B compare.
- R8: Field [11:10] selects the event line: 00 `tiob_i`, 01 `xc_i[0]`, 10 `xc_i[1]`, 11 `xc_i[2]`. Field [9:8] selects the edge: 00 none, 01 rising, 10 falling, 11 both. Lines are sampled at the clock, and the event occurs at the first edge that sees the new level.
- R9: A trigger is the software trigger, or the external event when bit 12 is set. A trigger loads count 0, sets the direction to up and restarts a stopped clock. It wins over the tick's own count update.
- R10: `clk_en_cmd_i` enables the clock and `clk_dis_cmd_i` disables it; disable wins when both are high. On a C compare, bit 6 set stops the clock (until a trigger) and bit 7 set disables it (until an enable command). `run_o` is high when the clock is both enabled and not stopped.
- R11: `ovf_o` pulses high for one cycle after a tick that wraps the count from 0xFFFF to 0 with bit 13 clear, and at no other time.
- R12: `tiob_oe_o` is high exactly when bit 15 is set and B is not in use as a trigger input (bit 12 set with field [11:10] = 00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 32 | Channel configuration word |
| ra_i | input | 16 | Compare value A |
| rb_i | input | 16 | Compare value B |
| rc_i | input | 16 | Compare value C / period |
| tick_i | input | 1 | Counter clock tick from the clock selector |
| clk_en_cmd_i | input | 1 | Clock enable command pulse |
| clk_dis_cmd_i | input | 1 | Clock disable command pulse |
| sw_trig_i | input | 1 | Software trigger pulse |
| tiob_i | input | 1 | Line B input level |
| xc_i | input | 3 | Auxiliary event lines |
| count_o | output | 16 | Counter value |
| ovf_o | output | 1 | Overflow pulse |
| run_o | output | 1 | Counter clock enabled and running |
| tioa_o | output | 1 | Output A |
| tiob_o | output | 1 | Output B level |
| tiob_oe_o | output | 1 | Output B drive enable |

## Verification
Count, outputs, run state and overflow are all registered, so each result is due at the first rising edge after the inputs that cause it. An external line change shows up one edge after the line moves. Only `tiob_oe_o` follows `mode_i` in the same cycle. The bench drives inputs at the falling edge, steps its model by one edge, and compares every output at the next falling edge. In this way each result is checked in the cycle it is due, and none is checked early or late.

// File: rtl/tc_wave_pkg.sv
package tc_wave_pkg;
  localparam int MODE_W   = 32;
  localparam int N_XC     = 3;
  localparam int N_SRC    = 4;  // per output: cmp, rc, ext, sw (rising priority)
  localparam int STOP_B   = 6;
  localparam int DISRC_B  = 7;
  localparam int EDGE_LSB = 8;
  localparam int SRC_LSB  = 10;
  localparam int ETRG_B   = 12;
  localparam int UPDN_B   = 13;
  localparam int RCTRG_B  = 14;
  localparam int WAVE_B   = 15;
  localparam int ACT_A_LSB = 16;
  localparam int ACT_B_LSB = 24;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef struct packed {
    logic                   wave;
    logic                   updown;
    logic                   rctrig;
    logic                   ext_trg;
    logic                   stop_rc;
    logic                   dis_rc;
    logic [1:0]             ev_src;
    logic [1:0]             ev_edge;
    logic [N_SRC-1:0][1:0]  act_a;
    logic [N_SRC-1:0][1:0]  act_b;
  } cfg_t;

  function automatic cfg_t decode_mode(input logic [MODE_W-1:0] m);
    cfg_t c;
    c.wave    = m[WAVE_B];
    c.updown  = m[UPDN_B];
    c.rctrig  = m[RCTRG_B];
    c.ext_trg = m[ETRG_B];
    c.stop_rc = m[STOP_B];
    c.dis_rc  = m[DISRC_B];
    c.ev_src  = m[SRC_LSB +: 2];
    c.ev_edge = m[EDGE_LSB +: 2];
    c.act_a   = m[ACT_A_LSB +: 2*N_SRC];
    c.act_b   = m[ACT_B_LSB +: 2*N_SRC];
    return c;
  endfunction
endpackage

// File: rtl/tc_evt_sel.sv
module tc_evt_sel #(
  parameter int N_XC = 3,
  localparam int SRC_W = $clog2(N_XC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [1:0]       edge_i,
  input  logic             tiob_i,
  input  logic [N_XC-1:0]  xc_i,
  output logic             ev_o
);
  logic [N_XC:0] lines;
  logic          sel, sel_q;

  assign lines = {xc_i, tiob_i};
  assign sel   = (int'(src_i) <= N_XC) ? lines[src_i] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel;
  end

  assign ev_o = en_i & ((edge_i[0] & sel & ~sel_q) | (edge_i[1] & ~sel & sel_q));

  // R8
  evt_needs_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/tc_cnt_core.sv
module tc_cnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             updown_i,
  input  logic             rctrig_i,
  input  logic [CNT_W-1:0] rc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, top;
  logic             dn_q, dn_d, ovf_d, ovf_q;

  always_comb begin
    top   = rctrig_i ? rc_i : MAXV;
    cnt_d = cnt_q;
    dn_d  = dn_q;
    ovf_d = 1'b0;
    if (trig_i) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick_i) begin
      if (updown_i) begin
        if (!dn_q) begin
          if (cnt_q == top) begin
            dn_d  = 1'b1;
            cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            dn_d  = 1'b0;
            cnt_d = (top == '0) ? '0 : ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end else begin
        dn_d = 1'b0;
        if (rctrig_i && cnt_q == rc_i) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + ONE;
          ovf_d = (cnt_q == MAXV);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !trig_i) |=> $stable(cnt_o));
  // R9
  trig_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (cnt_o == '0));
  // R11
  ovf_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_o == '0));
  // R5
  updown_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && updown_i && !trig_i) |=>
      (cnt_o == $past(cnt_o) + ONE || cnt_o == $past(cnt_o) - ONE ||
       (cnt_o == '0 && $past(cnt_o) == '0)));
endmodule

// File: rtl/tc_run_ctl.sv
module tc_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_cmd_i,
  input  logic dis_cmd_i,
  input  logic trig_i,
  input  logic rc_ev_i,
  input  logic stop_rc_i,
  input  logic dis_rc_i,
  output logic en_o,
  output logic run_o
);
  logic en_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b1;
    end else begin
      if (dis_cmd_i)                 en_q <= 1'b0;
      else if (en_cmd_i)             en_q <= 1'b1;
      else if (rc_ev_i && dis_rc_i)  en_q <= 1'b0;

      if (trig_i)                    run_q <= 1'b1;
      else if (rc_ev_i && stop_rc_i) run_q <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign run_o = run_q;

  // R10
  dis_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_cmd_i |=> !en_o);
  // R9
  trig_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> run_o);
endmodule

// File: rtl/tc_out_act.sv
module tc_out_act #(
  parameter int N_SRC = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       ev_i,
  input  logic [N_SRC-1:0][1:0]  act_i,
  output logic                   out_o
);
  import tc_wave_pkg::*;

  logic out_q, out_d, fire;

  // highest index with a live action wins
  always_comb begin
    out_d = out_q;
    fire  = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (!fire && ev_i[i] && act_i[i] != ACT_NONE) begin
        fire = 1'b1;
        case (act_e'(act_i[i]))
          ACT_SET: out_d = 1'b1;
          ACT_CLR: out_d = 1'b0;
          ACT_TGL: out_d = ~out_q;
          default: out_d = out_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  // R6
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(out_o));
  // R7
  top_src_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i[N_SRC-1] && act_i[N_SRC-1] == 2'b01) |=> out_o);
endmodule

// File: rtl/tc_wave_chan.sv
module tc_wave_chan
  import tc_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  ra_i,
  input  logic [CNT_W-1:0]  rb_i,
  input  logic [CNT_W-1:0]  rc_i,
  input  logic              tick_i,
  input  logic              clk_en_cmd_i,
  input  logic              clk_dis_cmd_i,
  input  logic              sw_trig_i,
  input  logic              tiob_i,
  input  logic [N_XC-1:0]   xc_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o,
  output logic              run_o,
  output logic              tioa_o,
  output logic              tiob_o,
  output logic              tiob_oe_o
);
  cfg_t cfg;
  logic ext_ev, sw_ev, trig, cnt_tick;
  logic ra_ev, rb_ev, rc_ev, clk_en, clk_run;
  logic unused_mode;
  logic [1:0][N_SRC-1:0]      ev_all;
  logic [1:0][N_SRC-1:0][1:0] act_all;
  logic [1:0]                 out_all;

  assign cfg         = decode_mode(mode_i);
  assign unused_mode = ^mode_i[5:0];

  tc_evt_sel #(.N_XC(N_XC)) u_evt (
    .clk_i, .rst_ni,
    .en_i   (cfg.wave),
    .src_i  (cfg.ev_src),
    .edge_i (cfg.ev_edge),
    .tiob_i,
    .xc_i,
    .ev_o   (ext_ev)
  );

  assign sw_ev    = cfg.wave & sw_trig_i;
  assign trig     = sw_ev | (ext_ev & cfg.ext_trg);
  assign cnt_tick = tick_i & clk_en & clk_run & cfg.wave;
  assign ra_ev    = cnt_tick & (count_o == ra_i);
  assign rb_ev    = cnt_tick & (count_o == rb_i);
  assign rc_ev    = cnt_tick & (count_o == rc_i);

  tc_cnt_core #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i   (cnt_tick),
    .trig_i   (trig),
    .updown_i (cfg.updown),
    .rctrig_i (cfg.rctrig),
    .rc_i,
    .cnt_o    (count_o),
    .ovf_o
  );

  tc_run_ctl u_run (
    .clk_i, .rst_ni,
    .en_cmd_i  (clk_en_cmd_i),
    .dis_cmd_i (clk_dis_cmd_i),
    .trig_i    (trig),
    .rc_ev_i   (rc_ev),
    .stop_rc_i (cfg.stop_rc),
    .dis_rc_i  (cfg.dis_rc),
    .en_o      (clk_en),
    .run_o     (clk_run)
  );

  assign ev_all[0]  = {sw_ev, ext_ev, rc_ev, ra_ev};
  assign ev_all[1]  = {sw_ev, ext_ev, rc_ev, rb_ev};
  assign act_all[0] = cfg.act_a;
  assign act_all[1] = cfg.act_b;

  for (genvar g = 0; g < 2; g++) begin : g_out
    tc_out_act #(.N_SRC(N_SRC)) u_act (
      .clk_i, .rst_ni,
      .ev_i  (ev_all[g]),
      .act_i (act_all[g]),
      .out_o (out_all[g])
    );
  end

  assign tioa_o    = out_all[0];
  assign tiob_o    = out_all[1];
  assign tiob_oe_o = cfg.wave & ~(cfg.ext_trg & (cfg.ev_src == 2'b00));
  assign run_o     = clk_en & clk_run;

  // R2
  idle_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[WAVE_B] |=> ($stable(count_o) && $stable(tioa_o) && $stable(tiob_o)));
endmodule

// File: tb/sim_tc_wave_chan.sv
`timescale 1ns/1ps
module sim_tc_wave_chan;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mode_i = '0;
  logic [15:0] ra_i = '0, rb_i = '0, rc_i = '0;
  logic        tick_i = 0, clk_en_cmd_i = 0, clk_dis_cmd_i = 0, sw_trig_i = 0, tiob_i = 0;
  logic [2:0]  xc_i = '0;
  logic [15:0] count_o;
  logic        ovf_o, run_o, tioa_o, tiob_o, tiob_oe_o;

  always #4 clk = ~clk;

  tc_wave_chan u0 (
    .clk_i(clk), .rst_ni, .mode_i, .ra_i, .rb_i, .rc_i, .tick_i,
    .clk_en_cmd_i, .clk_dis_cmd_i, .sw_trig_i, .tiob_i, .xc_i,
    .count_o, .ovf_o, .run_o, .tioa_o, .tiob_o, .tiob_oe_o
  );

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";

  // reference state, valid after the next rising edge
  logic [15:0] m_cnt = '0;
  logic m_dn = 0, m_en = 0, m_run = 1, m_oa = 0, m_ob = 0, m_ovf = 0, m_selq = 0;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic resolve(input logic [3:0] ev, input logic [7:0] acts, input logic cur);
    for (int i = 3; i >= 0; i--) begin
      if (ev[i] && acts[2*i +: 2] != 2'b00) begin
        case (acts[2*i +: 2])
          2'b01:   return 1'b1;
          2'b10:   return 1'b0;
          default: return ~cur;
        endcase
      end
    end
    return cur;
  endfunction

  task automatic model_step();
    logic w, ud, rt, et, sel, ext, sw, trg, tk, ra_e, rb_e, rc_e;
    logic [1:0] src, edg;
    logic [15:0] top;
    logic [3:0] lines;
    w = mode_i[15]; ud = mode_i[13]; rt = mode_i[14]; et = mode_i[12];
    src = mode_i[11:10]; edg = mode_i[9:8];
    lines = {xc_i, tiob_i};
    sel = lines[src];
    ext = w && ((edg[0] && sel && !m_selq) || (edg[1] && !sel && m_selq));
    m_selq = sel;
    sw  = w && sw_trig_i;
    trg = sw || (ext && et);
    tk  = tick_i && m_en && m_run && w;
    ra_e = tk && m_cnt == ra_i;
    rb_e = tk && m_cnt == rb_i;
    rc_e = tk && m_cnt == rc_i;
    m_oa = resolve({sw, ext, rc_e, ra_e}, mode_i[23:16], m_oa);
    m_ob = resolve({sw, ext, rc_e, rb_e}, mode_i[31:24], m_ob);
    m_ovf = 1'b0;
    top = rt ? rc_i : 16'hFFFF;
    if (trg) begin
      m_cnt = 0; m_dn = 0;
    end else if (tk) begin
      if (ud) begin
        if (!m_dn) begin
          if (m_cnt == top) begin m_dn = 1; m_cnt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1; end
          else m_cnt = m_cnt + 16'd1;
        end else begin
          if (m_cnt == 0) begin m_dn = 0; m_cnt = (top == 0) ? 16'd0 : 16'd1; end
          else m_cnt = m_cnt - 16'd1;
        end
      end else begin
        m_dn = 0;
        if (rt && m_cnt == rc_i) m_cnt = 0;
        else begin m_ovf = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 16'd1; end
      end
    end
    if (clk_dis_cmd_i) m_en = 0;
    else if (clk_en_cmd_i) m_en = 1;
    else if (rc_e && mode_i[7]) m_en = 0;
    if (trg) m_run = 1;
    else if (rc_e && mode_i[6]) m_run = 0;
  endtask

  task automatic cycle(input logic [31:0] md, input int p_tick, input int p_sw,
                       input int p_en, input int p_dis, input int p_xc);
    @(negedge clk);
    chk(cur_req, "count", 32'(count_o), 32'(m_cnt));
    chk(cur_req, "out A", 32'(tioa_o), 32'(m_oa));
    chk(cur_req, "out B", 32'(tiob_o), 32'(m_ob));
    chk(cur_req, "overflow", 32'(ovf_o), 32'(m_ovf));
    chk(cur_req, "run", 32'(run_o), 32'(m_en && m_run));
    chk(cur_req, "B drive", 32'(tiob_oe_o),
        32'(mode_i[15] && !(mode_i[12] && mode_i[11:10] == 2'b00)));
    mode_i        = md;
    tick_i        = int'($urandom % 100) < p_tick;
    sw_trig_i     = int'($urandom % 100) < p_sw;
    clk_en_cmd_i  = int'($urandom % 100) < p_en;
    clk_dis_cmd_i = int'($urandom % 100) < p_dis;
    for (int k = 0; k < 3; k++) if (int'($urandom % 100) < p_xc) xc_i[k] = ~xc_i[k];
    if (int'($urandom % 100) < p_xc) tiob_i = ~tiob_i;
    model_step();
  endtask

  task automatic phase(input string req, input int n, input logic [31:0] allow,
                       input logic [31:0] force_on, input int p_tick, input int p_sw,
                       input int p_en, input int p_dis, input int p_xc);
    logic [31:0] md;
    cur_req = req;
    rc_i = 16'($urandom_range(0, 40));
    ra_i = 16'($urandom_range(0, 45));
    rb_i = 16'($urandom_range(0, 45));
    md = ($urandom & allow) | force_on;
    cycle(md, p_tick, 0, 100, 0, 0);
    for (int i = 0; i < n; i++) begin
      if (i % 64 == 63) md = ($urandom & allow) | force_on;
      cycle(md, p_tick, p_sw, p_en, p_dis, p_xc);
    end
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int ovf_seen;
    void'($urandom(32'h5EED_0C17));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", 32'(count_o), 0);
    chk("R1", "out A", 32'(tioa_o), 0);
    chk("R1", "out B", 32'(tiob_o), 0);
    chk("R1", "overflow", 32'(ovf_o), 0);
    chk("R1", "run", 32'(run_o), 0);
    chk("R1", "B drive", 32'(tiob_oe_o), 0);

    phase("R2",  400, 32'hFFFF_7FFF, 32'h0000_0000, 80, 20, 5, 2, 30);
    phase("R3",  400, 32'hFFFF_0F3F, 32'h0000_8000, 75, 0, 2, 0, 0);
    phase("R4",  500, 32'hFFFF_0F3F, 32'h0000_C000, 80, 0, 2, 0, 0);
    phase("R5",  600, 32'hFFFF_4F3F, 32'h0000_A000, 80, 1, 2, 0, 0);
    phase("R6",  600, 32'hFFFF_7F3F, 32'h0000_8000, 70, 3, 2, 0, 10);
    phase("R7",  500, 32'hFFFF_7F3F, 32'h0000_8000, 70, 30, 2, 0, 40);
    phase("R8",  500, 32'hFFFF_6F3F, 32'h0000_8000, 70, 0, 2, 0, 40);
    phase("R9",  500, 32'hFFFF_7FFF, 32'h0000_9000, 70, 10, 2, 0, 30);
    phase("R10", 600, 32'hFFFF_FFFF, 32'h0000_8000, 70, 5, 10, 10, 20);
    phase("R12", 300, 32'hFFFF_F3FF, 32'h0000_9000, 70, 5, 2, 0, 30);

    // R11 directed wrap of the free-running counter
    cur_req = "R11";
    cycle(32'h0000_8000, 100, 0, 100, 0, 0);
    cycle(32'h0000_8000, 100, 100, 0, 0, 0);
    ovf_seen = 0;
    for (int i = 0; i < 65600; i++) begin
      cycle(32'h0000_8000, 100, 0, 0, 0, 0);
      if (ovf_o) ovf_seen++;
    end
    chk("R11", "wrap pulses", 32'(ovf_seen), 1);

    // R12 directed: B as trigger input is not driven, other sources drive it
    cur_req = "R12";
    cycle(32'h0000_9000, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R12", "B drive off", 32'(tiob_oe_o), 0);
    cycle(32'h0000_9400, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R12", "B drive on", 32'(tiob_oe_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule